// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer whose write side and read side run on independent clocks. Each side moves one word per rising edge of its own clock while its active-low enable is held low. A write is accepted only when the buffer has room. A read is accepted only when a word is stored. The read data lands in an output register, and an active-low output enable gates that register onto the output bus.

Five active-low status outputs describe the fill level: empty, full, more than half full, almost empty and almost full. The two almost thresholds are held in offset registers. They are written and read back over the ordinary data buses while the load input is low. A mode input chooses the source of the almost flags. In one setting they come from counts taken in their own clock domain. In the other they are computed combinationally from the live pointers of both domains. A rewind strobe on the read side moves the read pointer back to the first location, so a buffer that has never wrapped can replay its contents.

The pointers cross between the domains as Gray code through two flip-flop stages. The depth is a power-of-two parameter with a default of 64 words.

Top module: `dcfifo_flags`

## Requirements
- R1: After reset the block reports empty_n=0, full_n=1, half_full_n=1, almost_empty_n=0 and almost_full_n=1. With oe_n low, q_bus reads 0. Both threshold registers hold 7.
- R2: A write happens on a rising wclk edge when wr_en_n=0, ld_n=1 and full_n=1. A word offered while full_n=0 is dropped, and the stored contents and their order stay as they were.
- R3: A read happens on a rising rclk edge when rd_en_n=0, ld_n=1 and empty_n=1. It loads the oldest stored word into the output register, so words leave in write order. A read attempt while empty_n=0 leaves q_bus unchanged.
- R4: After a write into an empty buffer, empty_n rises on the second rising rclk edge after that write edge, and not earlier.
- R5: full_n falls right after the write edge that stores word number DEPTH. After a read from a full buffer, full_n rises on the second rising wclk edge after that read edge.
- R6: half_full_n is 0 exactly when the stored count, as seen in the write domain, is greater than DEPTH/2 (count 32 gives 1 and count 33 gives 0 at DEPTH=64).
- R7: With flag_async=0, almost_empty_n is 0 exactly when the count seen in the read domain is at or below the empty threshold.
- R8: almost_full_n is 0 exactly when the free space, DEPTH minus the count, is at or below the full threshold.
- R9: With ld_n=0, successive write transfers store wr_data[ADDR_W-1:0] alternately into the empty threshold and then the full threshold, starting with the empty threshold after reset. Successive read transfers return the empty threshold and then the full threshold, zero-extended on q_bus. Neither kind of transfer touches the data array or the pointers.
- R10: With flag_async=1, the almost flags follow the live write and read pointers. A write that lifts the count above the empty threshold therefore raises almost_empty_n before any rclk edge.
- R11: rewind=1 on a rising rclk edge sets the read pointer to location 0 and leaves the output register unchanged. Later reads return the words stored since reset, in order.
- R12: q_drive equals the inverse of oe_n. While oe_n=1, q_bus is 0. While oe_n=0, q_bus shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | 18 | Write data, or threshold value when loading |
| ld_n | input | 1 | Active-low select of the threshold registers instead of the array |
| rd_en_n | input | 1 | Active-low read enable |
| rewind | input | 1 | Active-high read-pointer rewind, sampled on rclk |
| oe_n | input | 1 | Active-low output enable |
| flag_async | input | 1 | 1 = almost flags from live pointers, 0 = per-domain flags |
| q_bus | output | 18 | Output register value, 0 while not enabled |
| q_drive | output | 1 | High while q_bus is being driven |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_full_n | output | 1 | Low when more than half full (write domain) |
| almost_empty_n | output | 1 | Low when count is at or below the empty threshold |
| almost_full_n | output | 1 | Low when free space is at or below the full threshold |

## Verification
The assertions assume that rst_n is held low for several edges of both clocks and is released cleanly. They also assume that rewind is never high in the same rclk cycle as a read enable, and that the writes since reset never exceed DEPTH when rewind is used. The bench holds to these assumptions: every scenario starts with a full reset, rewind is pulsed only while rd_en_n is high, and the rewind scenario stores only four words. Inputs change on falling clock edges. The two clocks run at the same frequency with a fixed 2 ns offset, so the synchronizer latency can be checked on a known edge.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dcf_pkg;
    // Which threshold register the next load transfer addresses.
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/dcf_ram.sv
// Storage array: written on wclk, read combinationally by address.
// Assumes: the read address is stable in the rclk domain around its edge.
module dcf_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the output register.
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/dcf_ptr_sync.sv
// Two-flop synchronizer for a Gray-coded pointer, plus conversion back to binary.
// Assumes: the source changes by at most one Gray bit per source clock.
module dcf_ptr_sync #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stage1;
    logic [PW-1:0] stage2;

    // Move the foreign pointer through two flip-flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Turn the synchronized Gray value back into binary, starting at the top bit.
    always_comb begin
        bin_out[PW-1] = stage2[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2[i];
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
// Write-side control: write pointer, full and half-full flags, the
// per-domain almost-full flag and both threshold registers.
// Assumes: rsync_bin is the read pointer already synchronized to wclk.
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 18,
    parameter int OFS_RST = 7
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W:0]   rsync_bin,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic [ADDR_W-1:0] full_ofs,
    output logic              full_n,
    output logic              half_full_n,
    output logic              af_sync_n
);
    localparam int            PW      = ADDR_W + 1;
    localparam int            DEPTH   = 1 << ADDR_W;
    localparam logic [PW-1:0] CNT_MAX = PW'(DEPTH);
    localparam logic [PW-1:0] CNT_HLF = PW'(DEPTH / 2);

    logic [PW-1:0] wcount;
    logic [PW-1:0] wbin_nx;
    logic          ld_we;
    ofs_sel_e      wsel;

    // Fill level and flags from registers of this domain only.
    always_comb begin
        wcount      = wbin - rsync_bin;
        full_n      = (wcount != CNT_MAX);
        half_full_n = !(wcount > CNT_HLF);
        af_sync_n   = !((CNT_MAX - wcount) <= {1'b0, full_ofs});
        mem_we      = !wr_en_n && ld_n && full_n;
        ld_we       = !wr_en_n && !ld_n;
        wbin_nx     = wbin + PW'(1);
    end

    // Advance the binary and Gray write pointers on every accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (mem_we) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Load the threshold registers alternately while ld_n is low.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            empty_ofs <= ADDR_W'(OFS_RST);
            full_ofs  <= ADDR_W'(OFS_RST);
            wsel      <= SEL_EMPTY_OFS;
        end else if (ld_we) begin
            if (wsel == SEL_EMPTY_OFS) begin
                empty_ofs <= wr_data[ADDR_W-1:0];
                wsel      <= SEL_FULL_OFS;
            end else begin
                full_ofs  <= wr_data[ADDR_W-1:0];
                wsel      <= SEL_EMPTY_OFS;
            end
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
// Read-side control: read pointer with rewind, empty flag, the per-domain
// almost-empty flag and the output register (array data or threshold readback).
// Assumes: the threshold registers are static while they are read back or
// compared here; rewind and a read are never requested in the same cycle.
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              ld_n,
    input  logic              rewind,
    input  logic [ADDR_W:0]   wsync_bin,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [ADDR_W-1:0] full_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q_reg,
    output logic              empty_n,
    output logic              ae_sync_n
);
    localparam int PW  = ADDR_W + 1;
    localparam int PAD = DATA_W - ADDR_W;

    logic [PW-1:0] rcount;
    logic [PW-1:0] rbin_nx;
    logic          rd_fire;
    logic          ld_re;
    ofs_sel_e      rsel;

    // Fill level and flags from registers of this domain only.
    always_comb begin
        rcount    = wsync_bin - rbin;
        empty_n   = (rcount != '0);
        ae_sync_n = !(rcount <= {1'b0, empty_ofs});
        rd_fire   = !rd_en_n && ld_n && empty_n && !rewind;
        ld_re     = !rd_en_n && !ld_n;
        if (rewind) begin
            rbin_nx = '0;
        end else if (rd_fire) begin
            rbin_nx = rbin + PW'(1);
        end else begin
            rbin_nx = rbin;
        end
    end

    // Update the binary and Gray read pointers.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Capture array data on a read, or a threshold on a load read.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            q_reg <= '0;
            rsel  <= SEL_EMPTY_OFS;
        end else if (ld_re) begin
            if (rsel == SEL_EMPTY_OFS) begin
                q_reg <= {{PAD{1'b0}}, empty_ofs};
                rsel  <= SEL_FULL_OFS;
            end else begin
                q_reg <= {{PAD{1'b0}}, full_ofs};
                rsel  <= SEL_EMPTY_OFS;
            end
        end else if (rd_fire) begin
            q_reg <= mem_rdata;
        end
    end
endmodule

// File: rtl/dcfifo_flags.sv
// Dual-clock FIFO top: joins the write and read control, the array and both
// pointer synchronizers, and builds the live-pointer almost flags.
// Assumes: reset is held for several edges of both clocks; ADDR_W < DATA_W.
module dcfifo_flags #(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 18,
    parameter int OFS_RST = 7
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_n,
    input  logic              rd_en_n,
    input  logic              rewind,
    input  logic              oe_n,
    input  logic              flag_async,
    output logic [DATA_W-1:0] q_bus,
    output logic              q_drive,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_full_n,
    output logic              almost_empty_n,
    output logic              almost_full_n
);
    localparam int            PW      = ADDR_W + 1;
    localparam int            DEPTH   = 1 << ADDR_W;
    localparam logic [PW-1:0] CNT_MAX = PW'(DEPTH);

    logic [PW-1:0]     wbin, wgray, rbin, rgray;
    logic [PW-1:0]     rsync_bin, wsync_bin;
    logic [PW-1:0]     live_cnt;
    logic [ADDR_W-1:0] empty_ofs, full_ofs;
    logic [DATA_W-1:0] mem_rdata, q_reg;
    logic              mem_we, af_sync_n, ae_sync_n;
    logic              ae_live_n, af_live_n;

    dcf_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_RST(OFS_RST)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .ld_n(ld_n),
        .wr_data(wr_data), .rsync_bin(rsync_bin), .wbin(wbin), .wgray(wgray),
        .mem_we(mem_we), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .full_n(full_n), .half_full_n(half_full_n), .af_sync_n(af_sync_n)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .ld_n(ld_n),
        .rewind(rewind), .wsync_bin(wsync_bin), .empty_ofs(empty_ofs),
        .full_ofs(full_ofs), .mem_rdata(mem_rdata), .rbin(rbin), .rgray(rgray),
        .q_reg(q_reg), .empty_n(empty_n), .ae_sync_n(ae_sync_n)
    );

    dcf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(wbin[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(rbin[ADDR_W-1:0]), .rdata(mem_rdata)
    );

    dcf_ptr_sync #(.PW(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rsync_bin)
    );

    dcf_ptr_sync #(.PW(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wsync_bin)
    );

    // Live-pointer almost flags, valid without waiting for a synchronizer.
    always_comb begin
        live_cnt  = wbin - rbin;
        ae_live_n = !(live_cnt <= {1'b0, empty_ofs});
        af_live_n = !((CNT_MAX - live_cnt) <= {1'b0, full_ofs});
    end

    // Pick the almost-flag source and gate the output register.
    always_comb begin
        almost_empty_n = flag_async ? ae_live_n : ae_sync_n;
        almost_full_n  = flag_async ? af_live_n : af_sync_n;
        q_drive        = !oe_n;
        q_bus          = oe_n ? '0 : q_reg;
    end
endmodule

// File: rtl/dcf_checker.sv
// Assertion checker for dcfifo_flags, attached through bind.
// Assumes: rewind is never high together with a read enable.
module dcf_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              full_n,
    input logic              empty_n,
    input logic              half_full_n,
    input logic              almost_full_n,
    input logic              almost_empty_n,
    input logic              flag_async,
    input logic              rd_en_n,
    input logic              rewind,
    input logic [ADDR_W:0]   wbin,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rbin,
    input logic [DATA_W-1:0] q_reg
);
    // R2 / R5: a full buffer accepts no write.
    assert_hold_when_full_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wbin));

    // R3: an empty buffer gives no read.
    assert_hold_when_empty_R3: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !rewind) |=> $stable(rbin));

    // R3: the output register only moves on a read request.
    assert_q_idle_R3: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_en_n |=> $stable(q_reg));

    // R4: the write pointer crosses with at most one bit changing per edge.
    assert_gray_step_R4: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R6: a full buffer is also more than half full.
    assert_full_implies_half_R6: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !flag_async) |-> !half_full_n);

    // R8: a full buffer is also almost full.
    assert_full_implies_af_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !flag_async) |-> !almost_full_n);

    // R7: an empty buffer is also almost empty in per-domain mode.
    assert_empty_implies_ae_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !flag_async) |-> !almost_empty_n);
endmodule

bind dcfifo_flags dcf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .empty_n(empty_n),
    .half_full_n(half_full_n), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .flag_async(flag_async), .rd_en_n(rd_en_n),
    .rewind(rewind), .wbin(wbin), .wgray(wgray), .rbin(rbin), .q_reg(q_reg)
);

// File: tb/dcfifo_flags_tb.sv
// Directed bench for dcfifo_flags: one task per scenario, each checking itself.
module dcfifo_flags_tb;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 18;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ld_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic              rewind = 1'b0;
    logic              oe_n = 1'b0;
    logic              flag_async = 1'b0;
    logic [DATA_W-1:0] q_bus;
    logic              q_drive, empty_n, full_n, half_full_n;
    logic              almost_empty_n, almost_full_n;

    int n_checks = 0;
    int n_fail   = 0;

    dcfifo_flags #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_RST(7)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .ld_n(ld_n), .rd_en_n(rd_en_n), .rewind(rewind),
        .oe_n(oe_n), .flag_async(flag_async), .q_bus(q_bus), .q_drive(q_drive),
        .empty_n(empty_n), .full_n(full_n), .half_full_n(half_full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    // 125 MHz on both sides; rclk rises 2 ns after wclk.
    always #4 wclk = ~wclk;
    initial begin
        #2;
        forever #4 rclk = ~rclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic do_reset(input logic async_mode);
        rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; ld_n = 1'b1;
        rewind = 1'b0; oe_n = 1'b0; flag_async = async_mode;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        settle();
    endtask

    // One write transfer; returns at the wclk falling edge after it.
    task automatic wr_word(input logic [DATA_W-1:0] d, input logic load);
        @(negedge wclk);
        wr_en_n = 1'b0; ld_n = !load; wr_data = d;
        @(negedge wclk);
        wr_en_n = 1'b1; ld_n = 1'b1;
    endtask

    // One read transfer; returns the bus value at the following rclk falling edge.
    task automatic rd_word(input logic load, output logic [DATA_W-1:0] d);
        @(negedge rclk);
        rd_en_n = 1'b0; ld_n = !load;
        @(negedge rclk);
        rd_en_n = 1'b1; ld_n = 1'b1;
        d = q_bus;
    endtask

    task automatic t_reset_state();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        check("R1 empty_n", empty_n, 0);
        check("R1 full_n", full_n, 1);
        check("R1 half_full_n", half_full_n, 1);
        check("R1 almost_empty_n", almost_empty_n, 0);
        check("R1 almost_full_n", almost_full_n, 1);
        check("R1 q_bus", q_bus, 0);
        rd_word(1'b1, d);
        check("R1 empty threshold", d, 7);
        rd_word(1'b1, d);
        check("R1 full threshold", d, 7);
        check("R9 load read leaves empty", empty_n, 0);
    endtask

    task automatic t_order();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) wr_word(DATA_W'(18'h2A000 + i * 3), 1'b0);
        settle();
        for (int i = 0; i < 5; i++) begin
            rd_word(1'b0, d);
            check("R3 order", d, 18'h2A000 + i * 3);
        end
        check("R3 empty after drain", empty_n, 0);
        rd_word(1'b0, d);
        check("R3 read while empty keeps q", d, 18'h2A00C);
    endtask

    task automatic t_empty_latency();
        do_reset(1'b0);
        wr_word(18'h15555, 1'b0);
        check("R4 empty_n after first rclk edge", empty_n, 0);
        @(posedge rclk); #1;
        check("R4 empty_n after second rclk edge", empty_n, 1);
    endtask

    task automatic t_fill();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        for (int i = 1; i <= DEPTH; i++) begin
            wr_word(DATA_W'(100 + i - 1), 1'b0);
            if (i == 32) check("R6 half_full_n at 32", half_full_n, 1);
            if (i == 33) check("R6 half_full_n at 33", half_full_n, 0);
            if (i == 56) check("R8 almost_full_n at free 8", almost_full_n, 1);
            if (i == 57) check("R8 almost_full_n at free 7", almost_full_n, 0);
            if (i == DEPTH - 1) check("R5 full_n at 63", full_n, 1);
        end
        check("R5 full_n at 64", full_n, 0);
        wr_word(18'h3FFFF, 1'b0);
        check("R2 write while full keeps full", full_n, 0);
        settle();
        rd_word(1'b0, d);
        check("R3 first of full", d, 100);
        check("R5 full_n right after read", full_n, 0);
        @(posedge wclk); #1;
        check("R5 full_n after one wclk edge", full_n, 0);
        @(posedge wclk); #1;
        check("R5 full_n after second wclk edge", full_n, 1);
        for (int k = 2; k <= DEPTH; k++) begin
            rd_word(1'b0, d);
            if (d !== DATA_W'(100 + k - 1)) check("R2 R3 drain order", d, 100 + k - 1);
            if (k == 56) check("R7 almost_empty_n at count 8", almost_empty_n, 1);
            if (k == 57) check("R7 almost_empty_n at count 7", almost_empty_n, 0);
        end
        check("R3 last word", d, 163);
        check("R2 dropped word not stored", empty_n, 0);
    endtask

    task automatic t_offsets();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        wr_word(18'h3FFC3, 1'b1);
        wr_word(18'h00032, 1'b1);
        rd_word(1'b1, d);
        check("R9 empty threshold readback", d, 3);
        rd_word(1'b1, d);
        check("R9 full threshold readback", d, 50);
        settle();
        check("R9 load leaves array empty", empty_n, 0);
        for (int i = 0; i < 3; i++) wr_word(DATA_W'(i + 1), 1'b0);
        settle();
        check("R9 R7 ae at count 3", almost_empty_n, 0);
        wr_word(4, 1'b0);
        settle();
        check("R9 R7 ae at count 4", almost_empty_n, 1);
        for (int i = 5; i <= 13; i++) wr_word(DATA_W'(i), 1'b0);
        check("R9 R8 af at free 51", almost_full_n, 1);
        wr_word(14, 1'b0);
        check("R9 R8 af at free 50", almost_full_n, 0);
        settle();
        rd_word(1'b0, d);
        check("R9 first array word", d, 1);
    endtask

    task automatic t_mode();
        do_reset(1'b0);
        for (int i = 0; i < 7; i++) wr_word(DATA_W'(i), 1'b0);
        settle();
        check("R7 sync ae at 7", almost_empty_n, 0);
        wr_word(7, 1'b0);
        check("R7 sync ae waits for rclk", almost_empty_n, 0);
        settle();
        check("R7 sync ae at 8", almost_empty_n, 1);
        do_reset(1'b1);
        for (int i = 0; i < 7; i++) wr_word(DATA_W'(i), 1'b0);
        settle();
        check("R10 async ae at 7", almost_empty_n, 0);
        wr_word(7, 1'b0);
        check("R10 async ae immediate", almost_empty_n, 1);
    endtask

    task automatic t_rewind();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) wr_word(DATA_W'(18'h10F00 + i), 1'b0);
        settle();
        for (int i = 0; i < 4; i++) rd_word(1'b0, d);
        check("R11 before rewind", empty_n, 0);
        @(negedge rclk); rewind = 1'b1;
        @(negedge rclk); rewind = 1'b0;
        check("R11 q unchanged by rewind", q_bus, 18'h10F03);
        check("R11 data available again", empty_n, 1);
        for (int i = 0; i < 4; i++) begin
            rd_word(1'b0, d);
            check("R11 replay", d, 18'h10F00 + i);
        end
    endtask

    task automatic t_oe();
        logic [DATA_W-1:0] d;
        do_reset(1'b0);
        wr_word(18'h2BEEF, 1'b0);
        settle();
        rd_word(1'b0, d);
        check("R12 q_bus enabled", d, 18'h2BEEF);
        check("R12 q_drive enabled", q_drive, 1);
        @(negedge rclk); oe_n = 1'b1; #1;
        check("R12 q_bus disabled", q_bus, 0);
        check("R12 q_drive disabled", q_drive, 0);
        @(negedge rclk); oe_n = 1'b0; #1;
        check("R12 q_bus re-enabled", q_bus, 18'h2BEEF);
    endtask

    initial begin
        t_reset_state();
        t_order();
        t_empty_latency();
        t_fill();
        t_offsets();
        t_mode();
        t_rewind();
        t_oe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule